// File: doc/BRIEF.md
# One-Time-Programmable Fuse Command Sequencer

This block sits between a simple register bus and a behavioural model of a one-time-programmable fuse array. Software uses a handful of word-wide registers to request fuse power, place a command with a word index, and poll a status word. Three commands exist. A shadow read copies one fuse word into a bus-visible shadow slot. A program burns the write-data register into one fuse word. A permanent lock turns a word index into a packed lock-row address and bit pattern, and burns that pattern.

Fuse power follows the request bit after a fixed delay. Each command raises busy for the array latency and then records the outcome in banked per-word error and disturbed flags. The fuse model only ever sets bits. A program that would clear a blown bit, or that targets a permanently locked word, fails and leaves the array untouched. Three lifecycle inputs are mirrored in the status word. The invalid input blocks every command.

Top module: `otpc_top`

## Requirements
- R1: Setting bit 0 of the configuration register (offset 0x000) sets the powered status bit (bit 5 of status, offset 0x00C) after PWR_DLY cycles. Clearing the request drops the powered bit after the same delay.
- R2: A control write (offset 0x004) with bits 9:8 = 00 and the word index in bits 7:0 copies that fuse word into the shadow window at 0x200 + 4*index. Busy (status bit 3) reads 1 on the cycle after the command and returns to 0 when the copy is done.
- R3: A control write with bits 9:8 = 01 writes the write-data register (offset 0x008) into the indexed fuse word. A later shadow read returns that value.
- R4: A program whose data has a 0 where the fuse word already holds a 1, or whose word is permanently locked, sets program-fail (status bit 4) and the word's error bit, and leaves the fuse word unchanged. Program-fail clears again on the next command that succeeds.
- R5: A command written while fuse power is off sets the error bit of its word, never raises busy, and changes no fuse or shadow contents.
- R6: While the invalid input is high (status bit 2), every control write is refused: busy stays low, the error banks stay unchanged and the fuse array stays unchanged.
- R7: A control write with bits 9:8 = 11 permanently locks word i. For i below UPPER, it sets pattern 0b11 << (2*i mod 16) in lock row i/8. For other words, it sets 0b1 << (i mod 16) in lock row UPPER/8 + (i-UPPER)/16. The per-word lock state reads back in banks at 0x04C + 4*(i>>5), bit i[4:0], and shows exactly the locked words.
- R8: Error flags live in banks at 0x034 + 4*(i>>5) and disturbed flags in banks at 0x01C + 4*(i>>5), at bit i[4:0]. When a command completes, the word's error bit takes the fail result and its disturbed bit takes the fuse_marginal input.
- R9: A bus write into the shadow window changes only the shadow slot. A following shadow read restores the fuse value.
- R10: Status bit 0 mirrors mode_secured, bit 8 mirrors mode_closed and bit 2 mirrors mode_invalid. All other status bits not named here read 0.
- R11: After reset, status, configuration and all flag and lock banks read 0.
- R12: A control write accepted while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data on bus_rdata next cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mode_secured | input | 1 | Lifecycle: secured |
| mode_closed | input | 1 | Lifecycle: closed |
| mode_invalid | input | 1 | Lifecycle: invalid, blocks commands |
| fuse_marginal | input | 1 | Sense-margin warning sampled at command completion |

## Verification
The bench programs every word with a distinct pattern and reads each one back. A design that decoded the index wrongly would alias words and show up in that sweep. It then locks every word in turn and compares all three lock banks with the set of words locked so far. A wrong shift or row formula in the lock encoding would lock a neighbour or miss the target. Other checks aim at one error each. A clear-a-blown-bit program that corrupts the word instead of failing is caught. So is a command issued while busy that restarts the array, and a window write that leaks into the fuses. Commands are also issued with power off and with invalid set; a design that still starts them shows busy or flips a fuse word.

// File: rtl/otpc_pkg.sv
package otpc_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_PROG = 2'b01,
    OP_NONE = 2'b10,
    OP_LOCK = 2'b11
  } fop_e;

  // Packed lock row that holds the lock bits of word idx
  function automatic int unsigned lock_row_of(int unsigned idx, int unsigned upper);
    if (idx < upper) return idx / 8;
    return upper / 8 + (idx - upper) / 16;
  endfunction

  // Bit pattern burnt into that row
  function automatic logic [15:0] lock_pat_of(int unsigned idx, int unsigned upper);
    if (idx < upper) return 16'h0003 << ((2 * idx) % 16);
    return 16'h0001 << (idx % 16);
  endfunction

endpackage

// File: rtl/otpc_power.sv
module otpc_power #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic powered
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      powered <= 1'b0;
      cnt_q   <= '0;
    end else if (req != powered) begin
      if (cnt_q == CW'(DLY - 1)) begin
        powered <= req;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  a_r1_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(powered) |-> $past(req));
  a_r1_fall_needs_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(powered) |-> !$past(req));

endmodule

// File: rtl/otpc_fuse_array.sv
module otpc_fuse_array
  import otpc_pkg::*;
#(
  parameter int NWORDS = 96,
  parameter int UPPER  = 32,
  parameter int LAT    = 3,
  parameter int AW     = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  fop_e              op,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              fail,
  output logic [NWORDS-1:0] locked
);
  localparam int LROWS = UPPER / 8 + (NWORDS - UPPER + 15) / 16;
  localparam int RW    = (LROWS > 1) ? $clog2(LROWS) : 1;
  localparam int CW    = $clog2(LAT + 1);

  logic [31:0]   mem  [NWORDS];
  logic [15:0]   rows [LROWS];
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] a_q;
  fop_e          op_q;
  logic [31:0]   wd_q, old_q;
  logic [RW-1:0] row_q;
  logic [15:0]   pat_q;
  logic          last, prog_bad;

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = '0;
    for (int r = 0; r < LROWS; r++) rows[r] = '0;
  end

  assign last     = run_q && (cnt_q == CW'(LAT - 1));
  assign prog_bad = ((old_q & ~wd_q) != 32'h0) || locked[a_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (start && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (last) begin
        run_q <= 1'b0;
        done  <= 1'b1;
        rdata <= old_q;
        fail  <= (op_q == OP_PROG) && prog_bad;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Operand capture and array ports, no reset so the word store maps to RAM
  always_ff @(posedge clk) begin
    if (start && !run_q) begin
      a_q   <= addr;
      op_q  <= op;
      wd_q  <= wdata;
      row_q <= RW'(lock_row_of(int'(addr), UPPER));
      pat_q <= lock_pat_of(int'(addr), UPPER);
      old_q <= mem[addr];
    end
    if (last && op_q == OP_PROG && !prog_bad) mem[a_q] <= wd_q;
  end

  always_ff @(posedge clk) begin
    if (last && op_q == OP_LOCK) rows[row_q] <= rows[row_q] | pat_q;
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_lk
    if (i < UPPER) begin : g_lo
      assign locked[i] = |rows[i / 8][(2 * i) % 16 +: 2];
    end else begin : g_hi
      assign locked[i] = rows[UPPER / 8 + (i - UPPER) / 16][i % 16];
    end
  end

  a_r12_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q);

  for (genvar r = 0; r < LROWS; r++) begin : g_chk
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      (rows[r] & $past(rows[r])) == $past(rows[r]));
  end

endmodule

// File: rtl/otpc_top.sv
module otpc_top
  import otpc_pkg::*;
#(
  parameter int NWORDS   = 96,
  parameter int UPPER    = 32,
  parameter int FUSE_LAT = 3,
  parameter int PWR_DLY  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        mode_secured,
  input  logic        mode_closed,
  input  logic        mode_invalid,
  input  logic        fuse_marginal
);
  localparam int AW        = $clog2(NWORDS);
  localparam int NB        = (NWORDS + 31) / 32;
  localparam int DIST_BASE = 'h01C;
  localparam int ERR_BASE  = 'h034;
  localparam int PLK_BASE  = 'h04C;

  logic [8:0]       cfg_q;
  logic [9:0]       ctrl_q;
  logic [31:0]      wd_q;
  logic             busy_q, pfail_q;
  logic [NB*32-1:0] err_q, dist_q, plk_vec;
  logic [AW-1:0]    cur_q;
  logic [31:0]      shadow [NWORDS];
  logic [31:0]      reg_q, sh_q, rd_mux, status;
  logic             sel_sh_q;

  logic              powered, a_done, a_fail;
  logic [31:0]       a_rdata;
  logic [NWORDS-1:0] locked;

  logic          wr_ctrl, cmd_ok, start;
  fop_e          cmd_op;
  logic [AW-1:0] cmd_idx;
  logic          win_hit, win_ok;
  logic [6:0]    win_idx;

  assign wr_ctrl = bus_wr && bus_addr == 12'h004;
  assign cmd_op  = fop_e'(bus_wdata[9:8]);
  assign cmd_idx = bus_wdata[AW-1:0];
  assign cmd_ok  = wr_ctrl && !mode_invalid && !busy_q && cmd_op != OP_NONE
                   && (32'(bus_wdata[7:0]) < 32'(NWORDS));
  assign start   = cmd_ok && powered;

  assign win_hit = bus_addr[11:9] == 3'b001;
  assign win_idx = bus_addr[8:2];
  assign win_ok  = win_hit && (32'(win_idx) < 32'(NWORDS));

  assign plk_vec = (NB*32)'(locked);
  assign status  = {23'h0, mode_closed, 2'b00, powered, pfail_q, busy_q,
                    mode_invalid, 1'b0, mode_secured};

  otpc_power #(.DLY(PWR_DLY)) i_power (
    .clk(clk), .rst(rst), .req(cfg_q[0]), .powered(powered)
  );

  otpc_fuse_array #(.NWORDS(NWORDS), .UPPER(UPPER), .LAT(FUSE_LAT), .AW(AW)) i_array (
    .clk(clk), .rst(rst), .start(start), .op(cmd_op), .addr(cmd_idx),
    .wdata(wd_q), .done(a_done), .rdata(a_rdata), .fail(a_fail), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      ctrl_q  <= '0;
      wd_q    <= '0;
      busy_q  <= 1'b0;
      pfail_q <= 1'b0;
      err_q   <= '0;
      dist_q  <= '0;
      cur_q   <= '0;
    end else begin
      if (bus_wr && bus_addr == 12'h000) cfg_q <= bus_wdata[8:0];
      if (bus_wr && bus_addr == 12'h008) wd_q  <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[9:0];
      if (start) begin
        busy_q <= 1'b1;
        cur_q  <= cmd_idx;
      end else if (cmd_ok) begin
        err_q[cmd_idx] <= 1'b1;
      end
      if (a_done) begin
        busy_q        <= 1'b0;
        pfail_q       <= a_fail;
        err_q[cur_q]  <= a_fail;
        dist_q[cur_q] <= fuse_marginal;
      end
    end
  end

  // Shadow store: one write port (array result first), one read port
  always_ff @(posedge clk) begin
    if (a_done && i_array.op_q == OP_READ) shadow[cur_q] <= a_rdata;
    else if (bus_wr && win_ok) shadow[win_idx[AW-1:0]] <= bus_wdata;
    if (bus_rd) sh_q <= shadow[win_idx[AW-1:0]];
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      12'h000: rd_mux = {23'h0, cfg_q};
      12'h004: rd_mux = {22'h0, ctrl_q};
      12'h008: rd_mux = wd_q;
      12'h00C: rd_mux = status;
      default: rd_mux = '0;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == 12'(DIST_BASE + 4 * b)) rd_mux = dist_q[b*32 +: 32];
      if (bus_addr == 12'(ERR_BASE + 4 * b))  rd_mux = err_q[b*32 +: 32];
      if (bus_addr == 12'(PLK_BASE + 4 * b))  rd_mux = plk_vec[b*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      sel_sh_q <= 1'b0;
    end else if (bus_rd) begin
      reg_q    <= rd_mux;
      sel_sh_q <= win_ok;
    end
  end

  assign bus_rdata = sel_sh_q ? sh_q : reg_q;

  a_r5_busy_needs_power: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(powered));
  a_r6_no_cmd_when_invalid: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !$past(mode_invalid));
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !a_done) |=> busy_q);
  a_r2_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    a_done |-> busy_q);
  a_r4_fail_on_prog: assert property (@(posedge clk) disable iff (rst)
    $rose(pfail_q) |-> $past(a_done));

endmodule

// File: tb/test_otpc_top.sv
module test_otpc_top;
  localparam int N = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mode_secured = 1'b0, mode_closed = 1'b0, mode_invalid = 1'b0;
  logic        fuse_marginal = 1'b0;

  int  checks = 0, fails = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  otpc_top #(.NWORDS(N), .UPPER(32), .FUSE_LAT(3), .PWR_DLY(4)) i_otpc_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_secured(mode_secured),
    .mode_closed(mode_closed), .mode_invalid(mode_invalid), .fuse_marginal(fuse_marginal)
  );

  function automatic logic [31:0] pat(int i);
    logic [7:0] b = 8'(i);
    return {b, ~b, b ^ 8'h5A, 8'hF0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 100; k++) begin
      rd(12'h00C, s);
      if (!s[3]) return;
    end
    check("R2 busy timeout", 32'h1, 32'h0);
  endtask

  task automatic cmd(logic [1:0] op, int idx);
    wr(12'h004, {22'h0, op, 8'(idx)});
    wait_idle();
  endtask

  task automatic shadow_of(int idx, output logic [31:0] d);
    cmd(2'b00, idx);
    rd(12'(12'h200 + 4 * idx), d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [95:0] lk;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd(12'h00C, v); check("R11 status", v, 32'h0);
    rd(12'h000, v); check("R11 cfg", v, 32'h0);
    for (int b = 0; b < 3; b++) begin
      rd(12'(12'h034 + 4 * b), v); check("R11 err bank", v, 32'h0);
      rd(12'(12'h01C + 4 * b), v); check("R11 dist bank", v, 32'h0);
      rd(12'(12'h04C + 4 * b), v); check("R11 lock bank", v, 32'h0);
    end

    // R10 lifecycle mirror
    mode_secured = 1'b1; mode_closed = 1'b1;
    rd(12'h00C, v); check("R10 status mirror", v, 32'h101);
    mode_secured = 1'b0; mode_closed = 1'b0;

    // R5 command with power off
    wr(12'h004, 32'h3);
    rd(12'h00C, v); check("R5 no busy unpowered", v[3], 1'b0);
    rd(12'h034, v); check("R5 err bit word3", v, 32'h8);

    // R1 power up
    wr(12'h000, 32'h1);
    rd(12'h00C, v); check("R1 not yet powered", v[5], 1'b0);
    repeat (6) @(negedge clk);
    rd(12'h00C, v); check("R1 powered", v, 32'h20);

    // R12 second command while busy; R2 busy seen
    wr(12'h008, 32'h0000_00F0);
    wr(12'h004, 32'h10A);
    wr(12'h004, 32'h10B);
    rd(12'h00C, v); check("R2 busy raised", v[3], 1'b1);
    wait_idle();
    shadow_of(10, v); check("R12 first cmd done", v, 32'h0000_00F0);
    shadow_of(11, v); check("R12 busy cmd ignored", v, 32'h0);

    // R3 program and R2 read-back sweep
    for (int i = 0; i < N; i++) begin
      wr(12'h008, pat(i));
      cmd(2'b01, i);
    end
    for (int i = 0; i < N; i++) begin
      shadow_of(i, v); check("R3 program sweep", v, pat(i));
    end
    for (int b = 0; b < 3; b++) begin
      rd(12'(12'h034 + 4 * b), v); check("R8 err clear after sweep", v, 32'h0);
    end

    // R4 clearing a blown bit
    wr(12'h008, pat(5) & ~32'h10);
    cmd(2'b01, 5);
    rd(12'h00C, v); check("R4 progfail", v[4], 1'b1);
    rd(12'h034, v); check("R4 err word5", v, 32'h20);
    shadow_of(5, v); check("R4 word unchanged", v, pat(5));
    rd(12'h00C, v); check("R4 progfail cleared", v[4], 1'b0);
    rd(12'h034, v); check("R8 err cleared on success", v, 32'h0);
    wr(12'h008, pat(6) | 32'hF);
    cmd(2'b01, 6);
    shadow_of(6, v); check("R3 superset program", v, pat(6) | 32'hF);

    // R8 disturbed flag
    fuse_marginal = 1'b1;
    cmd(2'b00, 40);
    fuse_marginal = 1'b0;
    rd(12'h020, v); check("R8 disturbed word40", v, 32'h100);
    cmd(2'b00, 40);
    rd(12'h020, v); check("R8 disturbed cleared", v, 32'h0);

    // R9 window write only touches shadow
    wr(12'h21C, 32'hDEAD_BEEF);
    rd(12'h21C, v); check("R9 window write", v, 32'hDEAD_BEEF);
    shadow_of(7, v); check("R9 fuse unchanged", v, pat(7));

    // R6 invalid refuses commands
    mode_invalid = 1'b1;
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h004, 32'h114);
    rd(12'h00C, v); check("R6 no busy when invalid", v, 32'h24);
    rd(12'h034, v); check("R6 err unchanged", v, 32'h0);
    mode_invalid = 1'b0;
    shadow_of(20, v); check("R6 fuse unchanged", v, pat(20));

    // R7 lock sweep: each word locks exactly itself
    lk = '0;
    for (int k = 0; k < N; k++) begin
      cmd(2'b11, k);
      lk[k] = 1'b1;
      for (int b = 0; b < 3; b++) begin
        rd(12'(12'h04C + 4 * b), v); check("R7 lock banks", v, lk[b*32 +: 32]);
      end
    end
    wr(12'h008, pat(50) | 32'h1);
    cmd(2'b01, 50);
    rd(12'h00C, v); check("R4 locked word fails", v[4], 1'b1);
    shadow_of(50, v); check("R7 locked word intact", v, pat(50));

    // R1 power down
    wr(12'h000, 32'h0);
    repeat (6) @(negedge clk);
    rd(12'h00C, v); check("R1 powered off", v[5], 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule